// File: doc/BRIEF.md
# Double-Buffered Frame Address Generator

This block produces the addresses that a serial-to-parallel converter uses to reach an external dual-port memory. That memory holds two frame-sized halves. In each 125 µs frame the converter fetches transmit bytes from one half and stores receive bytes into the same half. Meanwhile a processor works on the other half. At the end of each frame the converter swaps halves. Two level outputs, one per direction, show which half is in use. Each one toggles when its direction has finished with the final address of a frame.

The block keeps its own position within the frame. A frame-start pulse clears it and a channel tick advances it. Each cycle the converter may request a fetch address and a store address, each for a given stream. Fetches run two channels ahead of the current serial channel. Stores run one channel behind it. So a fetch near the end of a frame already addresses the next frame, and a store at the start of a frame still addresses the previous one. The rate mode sets the number of channels and streams and the memory map. The mode is captured only while reset is held.

Top module: `fa_addr_gen`

## Requirements
- R1: A fetch request registers `rd_addr_o = H*stride + c*S + s`. Here H is the current fetch half, s is the requested stream, and c = (current channel + 2) mod N, with N channels and S streams per direction in the latched mode.
- R2: A store request registers `wr_addr_o = H*stride + rx_off + c*S + s`. Here H is the current store half and c = (current channel − 1) mod N.
- R3: Mode encoding on `mode_i`: 2'b00 gives N=32, S=24, rx_off=0x400, stride=0x800, and address bit 12 is always 0. 2'b01 gives N=64, S=24, rx_off=0x800, stride=0x1000. 2'b10 and 2'b11 give N=128, S=12, rx_off=0x800, stride=0x1000.
- R4: `rd_blk_o` (or `wr_blk_o`) inverts at the clock edge that registers the accepted request for channel c = N−1 and stream S−1 in that direction. It changes at no other time.
- R5: A flag at 0 means that direction is using the lower half (H=0). A flag at 1 means the upper half. The half used by an address is the value the flag had before that request.
- R6: A request whose stream index is S or greater is ignored. No valid pulse is raised, the address output holds, and the flag does not change.
- R7: During reset and right after it, both flags and both valid outputs are 0 and the channel position is 0.
- R8: `mode_i` is captured on clock edges while `rst_ni` is low. Changes to it while out of reset have no effect.
- R9: `frame_start_i` clears the channel position to 0 and takes priority over `chan_tick_i`. `chan_tick_i` advances the position and wraps N−1 to 0. Both take effect for requests in the next cycle.
- R10: `rd_vld_o` / `wr_vld_o` is 1 for exactly the cycle after an accepted request, together with its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low; mode captured while low |
| mode_i | input | 2 | Rate mode select |
| frame_start_i | input | 1 | Frame boundary pulse, clears channel position |
| chan_tick_i | input | 1 | Advance channel position by one |
| rd_req_i | input | 1 | Fetch (transmit) address request |
| rd_strm_i | input | 5 | Stream index of the fetch request |
| wr_req_i | input | 1 | Store (receive) address request |
| wr_strm_i | input | 5 | Stream index of the store request |
| rd_addr_o | output | 13 | Registered fetch address |
| rd_vld_o | output | 1 | Fetch address valid |
| rd_blk_o | output | 1 | Fetch half flag |
| wr_addr_o | output | 13 | Registered store address |
| wr_vld_o | output | 1 | Store address valid |
| wr_blk_o | output | 1 | Store half flag |

## Verification
The checker asserts on every cycle that fetch addresses land in the transmit region and store addresses in the receive region. It also asserts that address bit 12 stays 0 in the slowest mode, that an address's half bit agrees with its flag, that a flag changes only together with a valid address, that reset leaves flags and valids low, and that the latched mode never moves out of reset. Only the bench scenarios can show the exact channel arithmetic: the lead and lag wrapping across frame ends, that a toggle happens on the last stream of the last channel, the priority of frame start over tick, and that out-of-range streams are dropped.

// File: rtl/fa_pkg.sv
package fa_pkg;

    localparam int ADDR_W     = 13;
    localparam int CHAN_W     = 7;
    localparam int STRM_W     = 5;
    localparam int MODE_W     = 2;
    localparam int LINES      = 24;
    localparam int BASE_CHANS = 32;
    localparam int BASE_RX    = 'h400;

    typedef enum logic [MODE_W-1:0] {
        RATE_2M     = 2'b00,
        RATE_4M     = 2'b01,
        RATE_8M     = 2'b10,
        RATE_8M_ALT = 2'b11
    } rate_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan_mask;
        logic [STRM_W-1:0] streams;
        logic [ADDR_W-1:0] rx_off;
        logic [ADDR_W-1:0] half_stride;
    } map_t;

    typedef struct packed {
        rate_e mode;
    } top_st_t;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
    } ctr_st_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              vld;
        logic              half;
    } port_st_t;

    // Channel count doubles per rate step; the fastest rate splits lines into in/out.
    function automatic map_t decode_map(rate_e r);
        map_t m;
        int   sh;
        sh = (r == RATE_2M) ? 0 : ((r == RATE_4M) ? 1 : 2);
        m.chan_mask   = CHAN_W'((BASE_CHANS << sh) - 1);
        m.streams     = (sh == 2) ? STRM_W'(LINES / 2) : STRM_W'(LINES);
        m.rx_off      = ADDR_W'(BASE_RX << ((sh == 0) ? 0 : 1));
        m.half_stride = ADDR_W'(BASE_RX << ((sh == 0) ? 1 : 2));
        return m;
    endfunction

endpackage

// File: rtl/fa_chan_ctr.sv
module fa_chan_ctr
    import fa_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              frame_start_i,
    input  logic              tick_i,
    input  logic [CHAN_W-1:0] chan_mask_i,
    output logic [CHAN_W-1:0] chan_o
);

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_start_i) begin
            st_d.chan = '0;
        end else if (tick_i) begin
            st_d.chan = (st_q.chan == chan_mask_i) ? '0 : st_q.chan + CHAN_W'(1);
        end
        if (!rst_ni) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign chan_o = st_q.chan;

endmodule

// File: rtl/fa_dir_port.sv
module fa_dir_port
    import fa_pkg::*;
#(
    parameter logic [CHAN_W-1:0] CHAN_OFS = CHAN_W'(2),
    parameter bit                IS_RX    = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  map_t              map_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic              req_i,
    input  logic [STRM_W-1:0] strm_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              vld_o,
    output logic              blk_o
);

    port_st_t          st_d, st_q;
    logic [CHAN_W-1:0] tgt;
    logic              ok;
    logic              last;
    logic [ADDR_W-1:0] half_base;
    logic [ADDR_W-1:0] reg_base;
    logic [ADDR_W-1:0] addr;

    always_comb begin
        tgt       = (chan_i + CHAN_OFS) & map_i.chan_mask;
        ok        = req_i && (strm_i < map_i.streams);
        last      = ok && (tgt == map_i.chan_mask)
                       && (strm_i == (map_i.streams - STRM_W'(1)));
        half_base = st_q.half ? map_i.half_stride : '0;
        reg_base  = IS_RX ? map_i.rx_off : '0;
        addr      = half_base + reg_base
                  + (ADDR_W'(tgt) * ADDR_W'(map_i.streams))
                  + ADDR_W'(strm_i);

        st_d     = st_q;
        st_d.vld = ok;
        if (ok) begin
            st_d.addr = addr;
        end
        if (last) begin
            st_d.half = ~st_q.half;
        end
        if (!rst_ni) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign addr_o = st_q.addr;
    assign vld_o  = st_q.vld;
    assign blk_o  = st_q.half;

endmodule

// File: rtl/fa_addr_gen.sv
module fa_addr_gen
    import fa_pkg::*;
#(
    parameter int RD_LEAD = 2,
    parameter int WR_LAG  = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              frame_start_i,
    input  logic              chan_tick_i,
    input  logic              rd_req_i,
    input  logic [STRM_W-1:0] rd_strm_i,
    input  logic              wr_req_i,
    input  logic [STRM_W-1:0] wr_strm_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              rd_vld_o,
    output logic              rd_blk_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              wr_vld_o,
    output logic              wr_blk_o
);

    localparam int                DIRS   = 2;
    localparam logic [CHAN_W-1:0] RD_OFS = CHAN_W'(RD_LEAD);
    localparam logic [CHAN_W-1:0] WR_OFS = CHAN_W'((1 << CHAN_W) - WR_LAG);

    top_st_t           st_d, st_q;
    logic [MODE_W-1:0] mode_q;
    map_t              map;
    logic [CHAN_W-1:0] chan;

    logic [DIRS-1:0]             req_v;
    logic [DIRS-1:0][STRM_W-1:0] strm_v;
    logic [DIRS-1:0][ADDR_W-1:0] addr_v;
    logic [DIRS-1:0]             vld_v;
    logic [DIRS-1:0]             blk_v;

    // Mode is only sampled while reset is held.
    always_comb begin
        st_d = st_q;
        if (!rst_ni) begin
            st_d.mode = rate_e'(mode_i);
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign mode_q = st_q.mode;
    assign map    = decode_map(st_q.mode);

    fa_chan_ctr i_chan_ctr (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .frame_start_i (frame_start_i),
        .tick_i        (chan_tick_i),
        .chan_mask_i   (map.chan_mask),
        .chan_o        (chan)
    );

    assign req_v  = {wr_req_i, rd_req_i};
    assign strm_v = {wr_strm_i, rd_strm_i};

    for (genvar g = 0; g < DIRS; g++) begin : g_dir
        localparam logic [CHAN_W-1:0] OFS = (g == 0) ? RD_OFS : WR_OFS;
        fa_dir_port #(
            .CHAN_OFS (OFS),
            .IS_RX    (g == 1)
        ) i_port (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .map_i  (map),
            .chan_i (chan),
            .req_i  (req_v[g]),
            .strm_i (strm_v[g]),
            .addr_o (addr_v[g]),
            .vld_o  (vld_v[g]),
            .blk_o  (blk_v[g])
        );
    end

    assign rd_addr_o = addr_v[0];
    assign rd_vld_o  = vld_v[0];
    assign rd_blk_o  = blk_v[0];
    assign wr_addr_o = addr_v[1];
    assign wr_vld_o  = vld_v[1];
    assign wr_blk_o  = blk_v[1];

endmodule

// File: rtl/fa_addr_gen_chk.sv
module fa_addr_gen_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [1:0]  mode_q,
    input logic [12:0] rd_addr_o,
    input logic        rd_vld_o,
    input logic        rd_blk_o,
    input logic [12:0] wr_addr_o,
    input logic        wr_vld_o,
    input logic        wr_blk_o
);

    logic rd_half_bit;
    logic wr_half_bit;
    assign rd_half_bit = (mode_q == 2'b00) ? rd_addr_o[11] : rd_addr_o[12];
    assign wr_half_bit = (mode_q == 2'b00) ? wr_addr_o[11] : wr_addr_o[12];

    // R1: fetch addresses stay in the transmit region
    a_r1_rd_in_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_vld_o |-> ((mode_q == 2'b00) ? !rd_addr_o[10] : !rd_addr_o[11]));

    // R2: store addresses stay in the receive region
    a_r2_wr_in_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_vld_o |-> ((mode_q == 2'b00) ? wr_addr_o[10] : wr_addr_o[11]));

    // R3: slowest mode never drives address bit 12
    a_r3_rd_bit12_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_vld_o && mode_q == 2'b00) |-> !rd_addr_o[12]);
    a_r3_wr_bit12_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_vld_o && mode_q == 2'b00) |-> !wr_addr_o[12]);

    // R4: a flag moves only together with a registered address
    a_r4_rd_flip_with_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(rd_blk_o) |-> rd_vld_o);
    a_r4_wr_flip_with_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(wr_blk_o) |-> wr_vld_o);

    // R5: address half agrees with flag when the flag did not just move
    a_r5_rd_half_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_vld_o && $stable(rd_blk_o)) |-> (rd_half_bit == rd_blk_o));
    a_r5_wr_half_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_vld_o && $stable(wr_blk_o)) |-> (wr_half_bit == wr_blk_o));

    // R7: leaving reset with flags and valids low
    a_r7_reset_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (!rd_blk_o && !wr_blk_o && !rd_vld_o && !wr_vld_o));

    // R8: latched mode holds out of reset
    a_r8_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> $stable(mode_q));

endmodule

bind fa_addr_gen fa_addr_gen_chk i_fa_addr_gen_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_q    (mode_q),
    .rd_addr_o (rd_addr_o),
    .rd_vld_o  (rd_vld_o),
    .rd_blk_o  (rd_blk_o),
    .wr_addr_o (wr_addr_o),
    .wr_vld_o  (wr_vld_o),
    .wr_blk_o  (wr_blk_o)
);

// File: tb/test_fa_addr_gen.sv
`timescale 1ns/1ps
module test_fa_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode;
    logic        fs, tick, rr, wr;
    logic [4:0]  rs, ws;
    logic [12:0] rd_addr, wr_addr;
    logic        rd_vld, rd_blk, wr_vld, wr_blk;

    always #4 clk = ~clk;

    fa_addr_gen i_fa_addr_gen (
        .clk_i (clk), .rst_ni (rst_n), .mode_i (mode),
        .frame_start_i (fs), .chan_tick_i (tick),
        .rd_req_i (rr), .rd_strm_i (rs), .wr_req_i (wr), .wr_strm_i (ws),
        .rd_addr_o (rd_addr), .rd_vld_o (rd_vld), .rd_blk_o (rd_blk),
        .wr_addr_o (wr_addr), .wr_vld_o (wr_vld), .wr_blk_o (wr_blk)
    );

    int    errs = 0;
    int    checks = 0;
    int    m_mode, m_cnt, m_rh, m_wh;
    string note = "";

    function automatic int n_chan(int m); return 32 << ((m >= 2) ? 2 : m); endfunction
    function automatic int n_strm(int m); return (m >= 2) ? 12 : 24; endfunction
    function automatic int rx_off(int m); return (m == 0) ? 'h400 : 'h800; endfunction
    function automatic int exp_addr(int m, int h, bit rx, int c, int s);
        return h * 2 * rx_off(m) + (rx ? rx_off(m) : 0) + c * n_strm(m) + s;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, note, act, exp);
        end
    endtask

    task automatic step(bit f, bit t, bit r, int rsi, bit w, int wsi);
        int n, s, rt, wt, era, ewa;
        bit erv, ewv;
        fs = f; tick = t; rr = r; rs = rsi[4:0]; wr = w; ws = wsi[4:0];
        @(posedge clk);
        n = n_chan(m_mode); s = n_strm(m_mode);
        rt = (m_cnt + 2) % n; wt = (m_cnt + n - 1) % n;
        erv = r && (rsi < s); ewv = w && (wsi < s);
        era = exp_addr(m_mode, m_rh, 1'b0, rt, rsi);
        ewa = exp_addr(m_mode, m_wh, 1'b1, wt, wsi);
        if (erv && rt == n - 1 && rsi == s - 1) m_rh ^= 1;
        if (ewv && wt == n - 1 && wsi == s - 1) m_wh ^= 1;
        if (f) m_cnt = 0; else if (t) m_cnt = (m_cnt + 1) % n;
        @(negedge clk);
        chk((r && !erv) ? "R6 rd ignored" : "R10 rd valid", int'(rd_vld), int'(erv));
        chk((w && !ewv) ? "R6 wr ignored" : "R10 wr valid", int'(wr_vld), int'(ewv));
        if (erv) chk("R1 R3 rd addr", int'(rd_addr), era);
        if (ewv) chk("R2 R3 wr addr", int'(wr_addr), ewa);
        chk((r && !erv) ? "R6 rd flag held" : "R4 R5 rd flag", int'(rd_blk), m_rh);
        chk((w && !ewv) ? "R6 wr flag held" : "R4 R5 wr flag", int'(wr_blk), m_wh);
    endtask

    task automatic do_reset(int m);
        @(negedge clk);
        rst_n = 1'b0; mode = m[1:0];
        fs = 0; tick = 0; rr = 0; wr = 0; rs = 0; ws = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_mode = m; m_cnt = 0; m_rh = 0; m_wh = 0;
        chk("R7 rd flag reset", int'(rd_blk), 0);
        chk("R7 wr flag reset", int'(wr_blk), 0);
        chk("R7 rd valid reset", int'(rd_vld), 0);
        chk("R7 wr valid reset", int'(wr_vld), 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; mode = 0;
        fs = 0; tick = 0; rr = 0; wr = 0; rs = 0; ws = 0;
        for (int m = 0; m < 4; m++) begin
            int n, s;
            do_reset(m);
            n = n_chan(m); s = n_strm(m);
            // R7: channel position 0 right after reset (fetch targets channel 2)
            note = "R7 position";
            step(0, 0, 1, 0, 1, 0);
            // R8: drive a different mode while running
            mode = 2'((m + 1) % 4);
            note = "R8 mode ignored";
            step(1, 0, 0, 0, 0, 0);
            for (int f = 0; f < 3; f++) begin
                for (int c = 0; c < n; c++) begin
                    for (int k = 0; k < s; k++) begin
                        bit last_k;
                        int wsi;
                        last_k = (k == s - 1);
                        wsi = last_k ? s - 1 : int'($urandom_range(31));
                        step(0, last_k, last_k | ($urandom_range(9) != 0), k,
                             last_k | ($urandom_range(3) != 0), wsi);
                    end
                end
            end
            // R6: out-of-range stream when the fetch target is the last channel
            note = "R6 directed";
            while (m_cnt != n - 3) step(0, 1, 0, 0, 0, 0);
            step(0, 0, 1, s, 0, 0);
            step(0, 0, 1, 31, 1, 31);
            // R9: frame start wins over tick in the same cycle
            note = "R9 priority";
            step(0, 1, 0, 0, 0, 0);
            step(1, 1, 0, 0, 0, 0);
            step(0, 0, 1, 1, 1, 1);
            // R9: wrap from N-1 to 0
            note = "R9 wrap";
            while (m_cnt != n - 1) step(0, 1, 0, 0, 0, 0);
            step(0, 1, 0, 0, 0, 0);
            step(0, 0, 1, 3, 1, 3);
            note = "";
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #1500000;
        errs++;
        checks++;
        $display("FAIL watchdog expired R10 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule